// File: doc/BRIEF.md
# Serial Register-Bank Access Controller

This block is the slave side of a three-wire serial link (serial clock, data in, data out) with an optional active-low chip select. It fronts the register bank of a converter. Every access opens with an 8-bit command word. The command names one register and a direction, and that choice applies to the single transfer that follows. When the transfer ends, the controller again waits for a command. The block holds a command register, three 8-bit control registers (setup, clock, test), a 16-bit read-only result register fed from an external result port, and two 24-bit calibration words (zero-scale and full-scale). Each register has its own transfer length and its own power-on value.

The serial pins are brought into the system clock domain through a short synchroniser chain. Edges of the serial clock then become single-cycle events. Input bits are taken on rising serial-clock edges. Output bits advance only on falling edges, so a host can sample data out on the rising edge. The serial clock may run continuously or in bursts with gaps of any length. Data out floats whenever chip select is high.

Top module: `regbank_serial_ctrl`

## Requirements
- R1: After reset, reads return setup 0x01, clock 0x05, test 0x00, zero-scale calibration 0x1F4000 and full-scale calibration 0x5761AB.
- R2: A command word has bit 7 = 0 as a start marker, bits 6:4 as the register select (000 command, 001 setup, 010 clock, 011 data, 100 test, 101 spare, 110 zero-scale, 111 full-scale) and bit 3 = 1 for a read or 0 for a write. Bits 2:0 are stored. Reading the command register (select 000) returns the most recently accepted command word, including that read command itself.
- R3: A command word with bit 7 = 1 is ignored. It changes no register, and the next 8 bits are taken as a command.
- R4: Transfers are sent MSB first. They are 8 bits for command, setup, clock, test and spare, 16 bits for data, and 24 bits for each calibration word. A write followed by a read of the same register returns the written value.
- R5: After any register transfer completes, the next 8 bits are taken as a command word.
- R6: The data register takes the value on the result port in each cycle in which result-valid is high. A read returns the value held when its first output bit was loaded, even if a new result arrives during the read.
- R7: A 16-bit write aimed at the data register is consumed and then discarded, and the data register keeps its value.
- R8: The data-out value changes only after falling serial-clock edges. It is stable from one falling edge until after the next rising edge.
- R9: While chip select is high, data out is high impedance and serial-clock edges are ignored. A transfer that was interrupted by deselection resumes where it stopped once chip select is low again.
- R10: Gaps of any length between serial-clock pulses, within a command or within a data transfer, do not disturb the transfer.
- R11: Asserting reset in the middle of a transfer returns every register to its power-on value and puts the controller back to waiting for a command.
- R12: The spare select 101 carries an 8-bit transfer. Writes to it are discarded and reads return 0x00.
- R13: A write command with select 000 starts no data transfer, and the next 8 bits are taken as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset to power-on state |
| sclk | input | 1 | Serial clock from the host, asynchronous to clk |
| cs_n | input | 1 | Active-low chip select; tie low for pure three-wire use |
| din | input | 1 | Serial data from the host, sampled on rising sclk |
| sdo | output | 1 | Serial data to the host; high impedance while cs_n is high |
| result_data | input | DATA_W | New conversion result for the data register |
| result_valid | input | 1 | One-cycle strobe that loads result_data |

## Verification
The bench builds the block with its default parameters: 16-bit data, 24-bit calibration words and a two-stage synchroniser. With these values, all three transfer lengths are exercised against each other, including mixes where a short command sits directly before a 24-bit word. A serial-clock half period of six system clocks covers the full synchroniser and edge-detect delay, so data out can be sampled just before each rising edge. Long idle gaps, deselection in the middle of a command, and reset in the middle of a write are all reachable within a short run.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int unsigned CMD_W = 8;

  typedef enum logic [2:0] {
    SEL_COMM  = 3'b000,
    SEL_SETUP = 3'b001,
    SEL_CLOCK = 3'b010,
    SEL_DATA  = 3'b011,
    SEL_TEST  = 3'b100,
    SEL_SPARE = 3'b101,
    SEL_ZCAL  = 3'b110,
    SEL_FCAL  = 3'b111
  } rsel_e;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_XFER = 1'b1
  } phase_e;

  // Number of serial bits moved for one access of the given register.
  function automatic int unsigned xfer_len(rsel_e s, int unsigned data_w,
                                           int unsigned cal_w);
    case (s)
      SEL_DATA:           return data_w;
      SEL_ZCAL, SEL_FCAL: return cal_w;
      default:            return CMD_W;
    endcase
  endfunction

  // Registers whose content a host write may replace.
  function automatic logic reg_writable(rsel_e s);
    case (s)
      SEL_SETUP, SEL_CLOCK, SEL_TEST, SEL_ZCAL, SEL_FCAL: return 1'b1;
      default:                                           return 1'b0;
    endcase
  endfunction

  // A command word must start with a zero marker bit.
  function automatic logic cmd_word_ok(logic [CMD_W-1:0] w);
    return ~w[CMD_W-1];
  endfunction

endpackage

// File: rtl/rb_pin_sync.sv
module rb_pin_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic s_sel,
  output logic s_din,
  output logic rise_evt,
  output logic fall_evt
);

  // Chain bit order: {sclk, cs_n, din}; idle values are clock high, deselected.
  localparam logic [2:0] IDLE = 3'b110;

  logic [2:0] chain [SYNC_N];
  logic       s_sclk;
  logic       prev_sclk;

  genvar g;
  generate
    for (g = 0; g < int'(SYNC_N); g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= IDLE;
          else        chain[g] <= {sclk, cs_n, din};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= IDLE;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign s_sclk = chain[SYNC_N-1][2];
  assign s_sel  = ~chain[SYNC_N-1][1];
  assign s_din  = chain[SYNC_N-1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_sclk <= 1'b1;
    else        prev_sclk <= s_sclk;
  end

  assign rise_evt = s_sel &  s_sclk & ~prev_sclk;
  assign fall_evt = s_sel & ~s_sclk &  prev_sclk;

endmodule

// File: rtl/rb_shift_ctrl.sv
module rb_shift_ctrl
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CAL_W  = 24,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              s_din,
  input  logic [CAL_W-1:0]  rd_value,
  output rsel_e             rd_sel,
  output logic              wr_stb,
  output rsel_e             wr_sel,
  output logic [CAL_W-1:0]  wr_data,
  output logic              cmd_wr,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              word_done,
  output logic              word_msb,
  output logic              in_cmd,
  output logic              out_bit,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [CNT_W-1:0]  cur_len
);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CAL_W-1:0]   sh_in_q;
  logic [CAL_W-1:0]   sh_out_q;
  rsel_e              sel_q;
  logic               rd_q;
  logic               load_q;

  logic [CAL_W-1:0]   nxt_word;
  logic               last_bit;
  rsel_e              cmd_sel;
  logic               cmd_rd;
  logic               cmd_ok;
  logic               opens_xfer;

  always_comb begin
    nxt_word   = {sh_in_q[CAL_W-2:0], s_din};
    cur_len    = (phase_q == PH_CMD) ? CNT_W'(CMD_W)
                                     : CNT_W'(xfer_len(sel_q, DATA_W, CAL_W));
    last_bit   = (cnt_q == cur_len - 1'b1);
    cmd_sel    = rsel_e'(nxt_word[6:4]);
    cmd_rd     = nxt_word[3];
    cmd_ok     = cmd_word_ok(nxt_word[CMD_W-1:0]);
    opens_xfer = cmd_ok & (cmd_rd | (cmd_sel != SEL_COMM));
  end

  assign in_cmd    = (phase_q == PH_CMD);
  assign word_done = rise_evt & last_bit;
  assign word_msb  = nxt_word[CMD_W-1];
  assign cmd_wr    = word_done & in_cmd & cmd_ok;
  assign cmd_data  = nxt_word[CMD_W-1:0];
  assign wr_stb    = word_done & ~in_cmd & ~rd_q;
  assign wr_sel    = sel_q;
  assign wr_data   = nxt_word;
  assign rd_sel    = sel_q;
  assign out_bit   = sh_out_q[CAL_W-1];
  assign bit_cnt   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      cnt_q    <= '0;
      sh_in_q  <= '0;
      sh_out_q <= '0;
      sel_q    <= SEL_COMM;
      rd_q     <= 1'b0;
      load_q   <= 1'b0;
    end else if (rise_evt) begin
      sh_in_q <= nxt_word;
      if (last_bit) begin
        cnt_q <= '0;
        if (phase_q == PH_CMD) begin
          if (opens_xfer) begin
            phase_q <= PH_XFER;
            sel_q   <= cmd_sel;
            rd_q    <= cmd_rd;
            load_q  <= cmd_rd;
          end
        end else begin
          phase_q <= PH_CMD;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (fall_evt) begin
      if (load_q) begin
        sh_out_q <= rd_value;
        load_q   <= 1'b0;
      end else begin
        sh_out_q <= {sh_out_q[CAL_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/rb_reg_bank.sv
module rb_reg_bank
  import regbank_pkg::*;
#(
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       CAL_W     = 24,
  parameter logic [CMD_W-1:0]  SETUP_RST = 8'h01,
  parameter logic [CMD_W-1:0]  CLOCK_RST = 8'h05,
  parameter logic [CMD_W-1:0]  TEST_RST  = 8'h00,
  parameter logic [CAL_W-1:0]  ZCAL_RST  = 24'h1F4000,
  parameter logic [CAL_W-1:0]  FCAL_RST  = 24'h5761AB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              wr_stb,
  input  rsel_e             wr_sel,
  input  logic [CAL_W-1:0]  wr_data,
  input  logic              result_valid,
  input  logic [DATA_W-1:0] result_data,
  input  rsel_e             rd_sel,
  output logic [CAL_W-1:0]  rd_value,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [DATA_W-1:0] data_q
);

  logic [CMD_W-1:0] setup_q, clock_q, test_q;
  logic [CAL_W-1:0] zcal_q, fcal_q;
  logic             wr_ok;
  logic [CAL_W-1:0] raw;

  assign wr_ok = wr_stb & reg_writable(wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      setup_q <= SETUP_RST;
      clock_q <= CLOCK_RST;
      test_q  <= TEST_RST;
      zcal_q  <= ZCAL_RST;
      fcal_q  <= FCAL_RST;
    end else begin
      if (cmd_wr) cmd_q <= cmd_data;
      if (wr_ok) begin
        case (wr_sel)
          SEL_SETUP: setup_q <= wr_data[CMD_W-1:0];
          SEL_CLOCK: clock_q <= wr_data[CMD_W-1:0];
          SEL_TEST:  test_q  <= wr_data[CMD_W-1:0];
          SEL_ZCAL:  zcal_q  <= wr_data;
          SEL_FCAL:  fcal_q  <= wr_data;
          default:   ;
        endcase
      end
    end
  end

  // The result register only follows the external port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            data_q <= '0;
    else if (result_valid) data_q <= result_data;
  end

  always_comb begin
    case (rd_sel)
      SEL_COMM:  raw = CAL_W'(cmd_q);
      SEL_SETUP: raw = CAL_W'(setup_q);
      SEL_CLOCK: raw = CAL_W'(clock_q);
      SEL_DATA:  raw = CAL_W'(data_q);
      SEL_TEST:  raw = CAL_W'(test_q);
      SEL_ZCAL:  raw = zcal_q;
      SEL_FCAL:  raw = fcal_q;
      default:   raw = '0;
    endcase
    // Left-align so the register MSB is the first bit shifted out.
    rd_value = raw << (CAL_W - xfer_len(rd_sel, DATA_W, CAL_W));
  end

endmodule

// File: rtl/regbank_serial_ctrl.sv
module regbank_serial_ctrl
  import regbank_pkg::*;
#(
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       CAL_W     = 24,
  parameter int unsigned       SYNC_N    = 2,
  parameter logic [CMD_W-1:0]  SETUP_RST = 8'h01,
  parameter logic [CMD_W-1:0]  CLOCK_RST = 8'h05,
  parameter logic [CMD_W-1:0]  TEST_RST  = 8'h00,
  parameter logic [CAL_W-1:0]  ZCAL_RST  = 24'h1F4000,
  parameter logic [CAL_W-1:0]  FCAL_RST  = 24'h5761AB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              sdo,
  input  logic [DATA_W-1:0] result_data,
  input  logic              result_valid
);

  localparam int unsigned CNT_W = $clog2(CAL_W + 1);

  logic             s_sel, s_din, rise_evt, fall_evt;
  logic [CAL_W-1:0] rd_value;
  rsel_e            rd_sel, wr_sel;
  logic             wr_stb, cmd_wr;
  logic [CAL_W-1:0] wr_data;
  logic [CMD_W-1:0] cmd_data;
  logic             word_done, word_msb, in_cmd, out_bit;
  logic [CNT_W-1:0] bit_cnt, cur_len;
  logic [CMD_W-1:0] cmd_q;
  logic [DATA_W-1:0] data_q;

  rb_pin_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .din      (din),
    .s_sel    (s_sel),
    .s_din    (s_din),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  rb_shift_ctrl #(.DATA_W(DATA_W), .CAL_W(CAL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .s_din     (s_din),
    .rd_value  (rd_value),
    .rd_sel    (rd_sel),
    .wr_stb    (wr_stb),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .word_done (word_done),
    .word_msb  (word_msb),
    .in_cmd    (in_cmd),
    .out_bit   (out_bit),
    .bit_cnt   (bit_cnt),
    .cur_len   (cur_len)
  );

  rb_reg_bank #(
    .DATA_W(DATA_W), .CAL_W(CAL_W),
    .SETUP_RST(SETUP_RST), .CLOCK_RST(CLOCK_RST), .TEST_RST(TEST_RST),
    .ZCAL_RST(ZCAL_RST), .FCAL_RST(FCAL_RST)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .cmd_data     (cmd_data),
    .wr_stb       (wr_stb),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .result_valid (result_valid),
    .result_data  (result_data),
    .rd_sel       (rd_sel),
    .rd_value     (rd_value),
    .cmd_q        (cmd_q),
    .data_q       (data_q)
  );

  assign sdo = cs_n ? 1'bz : out_bit;

endmodule

// File: rtl/rb_access_chk.sv
module rb_access_chk #(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_sel,
  input logic              fall_evt,
  input logic              out_bit,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CNT_W-1:0]  cur_len,
  input logic              in_cmd,
  input logic              word_done,
  input logic              word_msb,
  input logic [7:0]        cmd_q,
  input logic [DATA_W-1:0] data_q,
  input logic              result_valid
);

  a_r8_out_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(out_bit));

  a_r9_deselect_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !s_sel |=> ($stable(bit_cnt) && $stable(in_cmd)));

  a_r3_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && in_cmd && word_msb) |=> (in_cmd && $stable(cmd_q)));

  a_r5_back_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !in_cmd) |=> in_cmd);

  a_r7_data_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |=> $stable(data_q));

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < cur_len);

endmodule

bind regbank_serial_ctrl rb_access_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .s_sel        (s_sel),
  .fall_evt     (fall_evt),
  .out_bit      (out_bit),
  .bit_cnt      (bit_cnt),
  .cur_len      (cur_len),
  .in_cmd       (in_cmd),
  .word_done    (word_done),
  .word_msb     (word_msb),
  .cmd_q        (cmd_q),
  .data_q       (data_q),
  .result_valid (result_valid)
);

// File: tb/regbank_serial_ctrl_tb_top.sv
module regbank_serial_ctrl_tb_top;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        cs_n = 1'b1;
  logic        din = 1'b0;
  logic        sdo;
  logic [15:0] result_data = '0;
  logic        result_valid = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [23:0] m [8];

  always #4 clk = ~clk;

  regbank_serial_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sdo(sdo), .result_data(result_data), .result_valid(result_valid)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R9: data out floats on every clock that chip select is high
  always @(negedge clk) begin
    if (cs_n === 1'b1 && !done) begin
      checks++;
      if (sdo !== 1'bz) begin
        failures++;
        $display("FAIL R9 sdo actual=%b expected=z", sdo);
      end
    end
  end

  function automatic int blen(input int s);
    if (s == 3) return 16;
    if (s >= 6) return 24;
    return 8;
  endfunction

  function automatic bit bwritable(input int s);
    return (s == 1) || (s == 2) || (s == 4) || (s == 6) || (s == 7);
  endfunction

  task automatic model_reset();
    m[0] = 24'h0;      m[1] = 24'h01; m[2] = 24'h05; m[3] = 24'h0;
    m[4] = 24'h0;      m[5] = 24'h0;  m[6] = 24'h1F4000; m[7] = 24'h5761AB;
  endtask

  // One serial bit; R8: output checked to hold through the rising edge.
  task automatic bit_xfer(input logic b, output logic o);
    @(negedge clk);
    sclk = 1'b0;
    din  = b;
    repeat (HALF) @(negedge clk);
    o = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    checks++;
    if (sdo !== o) begin
      failures++;
      $display("FAIL R8 sdo moved after rising edge actual=%b expected=%b", sdo, o);
    end
  endtask

  task automatic send_bits(input logic [23:0] v, input int n, output logic [23:0] got);
    logic o;
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_xfer(v[i], o);
      got[i] = o;
    end
  endtask

  task automatic wr_reg(input int s, input logic [23:0] val);
    logic [23:0] g;
    logic [7:0]  c;
    c = {1'b0, 3'(s), 1'b0, 3'b000};
    send_bits({16'h0, c}, 8, g);
    m[0] = {16'h0, c};
    send_bits(val, blen(s), g);
    if (bwritable(s)) m[s] = val & ((24'h1 << blen(s)) - 24'h1);
  endtask

  task automatic rd_reg(input int s, input logic [2:0] low, input string tag);
    logic [23:0] g;
    logic [7:0]  c;
    c = {1'b0, 3'(s), 1'b1, low};
    send_bits({16'h0, c}, 8, g);
    m[0] = {16'h0, c};
    send_bits(24'h0, blen(s), g);
    check(tag, g, m[s]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (5) @(negedge clk);
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_result(input logic [15:0] v);
    @(negedge clk);
    result_data = v; result_valid = 1'b1;
    @(negedge clk);
    result_valid = 1'b0;
    m[3] = {8'h0, v};
  endtask

  initial begin
    logic [23:0] g, g2;
    logic o;
    model_reset();
    repeat (3) @(negedge clk);
    do_reset();

    // R1 power-on values
    rd_reg(1, 3'b000, "R1 setup");
    rd_reg(2, 3'b000, "R1 clock");
    rd_reg(4, 3'b000, "R1 test");
    rd_reg(6, 3'b000, "R1 zcal");
    rd_reg(7, 3'b000, "R1 fcal");

    // R4 write/read of every writable register; R5 by back-to-back commands
    wr_reg(1, 24'hA5);
    wr_reg(2, 24'h3C);
    wr_reg(4, 24'h81);
    wr_reg(6, 24'h123456);
    wr_reg(7, 24'hFEDCBA);
    rd_reg(1, 3'b000, "R4 setup");
    rd_reg(2, 3'b000, "R4 clock");
    rd_reg(4, 3'b000, "R4 test");
    rd_reg(6, 3'b000, "R4 zcal");
    rd_reg(7, 3'b000, "R5 fcal after 24-bit write");

    // R2 command register read returns the read command itself
    rd_reg(0, 3'b101, "R2 command readback");

    // R3 bad start marker ignored
    send_bits(24'hB8, 8, g);
    rd_reg(1, 3'b000, "R3 after ignored command");

    // R6 result loading and snapshot during read
    pulse_result(16'hBEEF);
    send_bits(24'h38, 8, g);
    m[0] = 24'h38;
    send_bits(24'h0, 4, g);
    pulse_result(16'h1234);
    send_bits(24'h0, 12, g2);
    check("R6 snapshot during read", {8'h0, g[3:0], g2[11:0]}, 24'hBEEF);
    rd_reg(3, 3'b000, "R6 new result");

    // R7 write to data register discarded
    wr_reg(3, 24'hFFFF);
    rd_reg(3, 3'b000, "R7 data unchanged");

    // R12 spare select
    wr_reg(5, 24'h77);
    rd_reg(5, 3'b000, "R12 spare reads zero");

    // R13 write command to select 000 opens no transfer
    send_bits(24'h00, 8, g);
    m[0] = 24'h0;
    rd_reg(1, 3'b000, "R13 after select-000 write");

    // R10 long gaps inside command and inside read
    send_bits(24'h2, 4, g);
    repeat (300) @(negedge clk);
    send_bits(24'h8, 4, g);
    m[0] = 24'h28;
    send_bits(24'h0, 3, g);
    repeat (500) @(negedge clk);
    send_bits(24'h0, 5, g2);
    check("R10 read across gaps", {16'h0, g[2:0], g2[4:0]}, m[2]);

    // R9 deselect mid-command; edges while deselected ignored
    send_bits(24'h1, 4, g);
    @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b0; din = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    send_bits(24'h8, 4, g);
    m[0] = 24'h18;
    send_bits(24'h0, 8, g);
    check("R9 resume after deselect", g, m[1]);

    // R11 reset mid-write
    send_bits(24'h10, 8, g);
    send_bits(24'hF, 4, g);
    do_reset();
    rd_reg(1, 3'b000, "R11 setup after reset");
    rd_reg(6, 3'b000, "R11 zcal after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule